// File: doc/BRIEF.md
# USB device interrupt aggregator

This block turns the single-cycle event strobes of a USB device protocol engine into sticky status flags and folds them into one interrupt request for a small CPU. Every endpoint keeps five flags: IN data taken by the host, OUT data stored in bank 0, OUT data stored in bank 1, SETUP accepted and STALL handshake sent. The device as a whole keeps three flags: start of frame seen, bus suspend seen and resume wake-up while suspended.

The CPU reaches the block through a simple register port. It writes enable masks, a two-bit priority level, the global and USB interrupt gates, the per-endpoint double-bank and isochronous configuration, and it clears flags by writing ones to them. The read side is combinational, so the CPU can see any flag or setting on the cycle it presents an address. The interrupt request is a registered level. The priority level goes straight to the interrupt controller, where vectoring takes place.

Top module: `usb_irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset all flags, enable masks and configuration registers are 0, the device is not suspended and `irq` is 0.
- R2: `irq` is a registered level. In the cycle after any cycle in which the global gate (control bit 0) and the USB gate (control bit 1) are both 1 and at least one flag is set together with its enable bit, it is 1. Otherwise it is 0.
- R3: `irq_level` equals {control bit 3, control bit 2}. 2'b00 is the lowest priority and 2'b11 the highest.
- R4: Each flag stays set until the CPU writes a 1 to its bit at the flag register address. Writing 0 leaves the flag unchanged. If an event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R5: An endpoint's flags register holds: bit 0 IN taken (set by `ep_tx_ack`), bit 1 OUT in bank 0 (`ep_out_b0`), bit 2 OUT in bank 1, bit 3 SETUP accepted (`ep_setup`), bit 4 STALL sent. Each is set on the clock edge that follows its strobe.
- R6: The bank-1 flag is set by `ep_out_b1` only on an endpoint whose bit in the double-bank register (address 3) is 1. While that bit is 0 the flag is held at 0, and clearing the bit clears the flag.
- R7: The STALL-sent flag is set by `ep_stall` unless the endpoint's bit in the isochronous register (address 4) is 1. An `ep_setup` on the same endpoint clears it. A STALL strobe in the same cycle wins.
- R8: The device flags register (address 1) holds: bit 0 start of frame (set by `bus_sof`), bit 1 suspend (set by `bus_suspend`), bit 2 wake-up.
- R9: A `bus_suspend` strobe puts the device into the suspended state, and a `bus_resume` or `bus_reset` strobe takes it out. `bus_resume` sets the wake-up flag only while the device is suspended.
- R10: Register map, all at data width 5. Address 0: control {prio_hi, prio_lo, usb_en, glob_en} in bits 3..0. Address 1: device flags. Address 2: device enables, in the same bit positions as the device flags. Address 3: double-bank mask, one bit per endpoint. Address 4: isochronous mask. Address 5+2e: flags of endpoint e. Address 6+2e: enables of endpoint e, in the same positions as its flags. `reg_rdata` shows the addressed register in the same cycle, and unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ep_tx_ack | input | NUM_EP | Per endpoint: host acknowledged an IN packet |
| ep_out_b0 | input | NUM_EP | Per endpoint: OUT packet stored in bank 0 |
| ep_out_b1 | input | NUM_EP | Per endpoint: OUT packet stored in bank 1 |
| ep_setup | input | NUM_EP | Per endpoint: SETUP packet accepted |
| ep_stall | input | NUM_EP | Per endpoint: STALL handshake sent |
| bus_sof | input | 1 | Start-of-frame packet received |
| bus_suspend | input | 1 | Bus suspend detected |
| bus_resume | input | 1 | Resume signalling detected |
| bus_reset | input | 1 | Bus reset detected |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Write address |
| reg_wdata | input | DATA_W | Write data, where a 1 clears a flag at the flag addresses |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | DATA_W | Read data, combinational |
| irq | output | 1 | Registered interrupt request level |
| irq_level | output | 2 | Priority level of the request, 00 lowest |

## Verification
A flag register stuck at the wrong value shows at `reg_rdata` in the same cycle its address is presented. It also shows at `irq` one clock later once its enable and both gates are set, so the bench reads back a random address and compares `irq` on every cycle. A lost or wrong suspended state cannot be seen directly. It shows only on the next `bus_resume`, as a wake-up flag that wrongly appears or fails to appear. The directed cases therefore place resume strobes before, during and after suspend, and around a bus reset. Masking faults, such as a bank-1 flag on a single-bank endpoint or a STALL flag on an isochronous one, show one cycle after the strobe at the endpoint's flag address.

// File: rtl/usbirq_pkg.sv
// Shared constants for the USB device interrupt aggregator: flag bit
// positions, control bit positions and the register address map.
package usbirq_pkg;

    localparam int EP_FLAG_W  = 5;
    localparam int DEV_FLAG_W = 3;
    localparam int CTL_W      = 4;

    // endpoint flag bit positions (enables use the same positions)
    localparam int EPF_TXDONE = 0;
    localparam int EPF_OUT0   = 1;
    localparam int EPF_OUT1   = 2;
    localparam int EPF_SETUP  = 3;
    localparam int EPF_STALL  = 4;

    // device flag bit positions
    localparam int DEVF_SOF  = 0;
    localparam int DEVF_SUSP = 1;
    localparam int DEVF_WAKE = 2;

    // control register bit positions
    localparam int CTL_GLOBAL  = 0;
    localparam int CTL_USB     = 1;
    localparam int CTL_PRIO_LO = 2;
    localparam int CTL_PRIO_HI = 3;

    // address map
    localparam int ADR_CTRL    = 0;
    localparam int ADR_DEVFLAG = 1;
    localparam int ADR_DEVEN   = 2;
    localparam int ADR_DBLBANK = 3;
    localparam int ADR_ISO     = 4;
    localparam int ADR_EP_BASE = 5;

endpackage

// File: rtl/usbirq_ep_flags.sv
// Flag and enable storage for one endpoint.
// Assumes: event strobes are one cycle wide; the clear and enable write
// strobes come already decoded for this endpoint.
module usbirq_ep_flags
    import usbirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_tx,
    input  logic                 evt_out0,
    input  logic                 evt_out1,
    input  logic                 evt_setup,
    input  logic                 evt_stall,
    input  logic                 dbl_bank,
    input  logic                 iso_ep,
    input  logic                 clr_wr,
    input  logic                 en_wr,
    input  logic [EP_FLAG_W-1:0] wdata,
    output logic [EP_FLAG_W-1:0] flags,
    output logic [EP_FLAG_W-1:0] enables,
    output logic                 req
);

    logic [EP_FLAG_W-1:0] set_v;
    logic [EP_FLAG_W-1:0] clr_v;
    logic [EP_FLAG_W-1:0] flags_d;

    // Purpose: form set and clear masks; events override clears.
    always_comb begin
        set_v            = '0;
        set_v[EPF_TXDONE] = evt_tx;
        set_v[EPF_OUT0]   = evt_out0;
        set_v[EPF_OUT1]   = evt_out1 & dbl_bank;
        set_v[EPF_SETUP]  = evt_setup;
        set_v[EPF_STALL]  = evt_stall & ~iso_ep;
        clr_v            = clr_wr ? wdata : '0;
        clr_v[EPF_STALL]  = clr_v[EPF_STALL] | evt_setup;
        flags_d          = (flags & ~clr_v) | set_v;
        if (!dbl_bank) begin
            flags_d[EPF_OUT1] = 1'b0;
        end
    end

    // Purpose: hold the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_d;
    end

    // Purpose: hold the per-flag enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)     enables <= '0;
        else if (en_wr) enables <= wdata;
    end

    assign req = |(flags & enables);

endmodule

// File: rtl/usbirq_dev_flags.sv
// Device-level flags (start of frame, suspend, wake-up) and the
// suspended-state tracker that arms the wake-up flag.
// Assumes: bus strobes are one cycle wide; a suspend strobe in the same
// cycle as resume or reset leaves the device suspended.
module usbirq_dev_flags
    import usbirq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sof,
    input  logic                  bus_suspend,
    input  logic                  bus_resume,
    input  logic                  bus_reset,
    input  logic                  clr_wr,
    input  logic                  en_wr,
    input  logic [DEV_FLAG_W-1:0] wdata,
    output logic [DEV_FLAG_W-1:0] flags,
    output logic [DEV_FLAG_W-1:0] enables,
    output logic                  suspended,
    output logic                  req
);

    logic [DEV_FLAG_W-1:0] set_v;
    logic [DEV_FLAG_W-1:0] clr_v;

    // Purpose: set mask from bus strobes; wake-up only counts while suspended.
    always_comb begin
        set_v            = '0;
        set_v[DEVF_SOF]  = bus_sof;
        set_v[DEVF_SUSP] = bus_suspend;
        set_v[DEVF_WAKE] = bus_resume & suspended;
        clr_v            = clr_wr ? wdata : '0;
    end

    // Purpose: hold the sticky device flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_v) | set_v;
    end

    // Purpose: track whether the bus is in the suspended state.
    always_ff @(posedge clk) begin
        if (!rst_n)                       suspended <= 1'b0;
        else if (bus_suspend)             suspended <= 1'b1;
        else if (bus_resume || bus_reset) suspended <= 1'b0;
    end

    // Purpose: hold the device enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)     enables <= '0;
        else if (en_wr) enables <= wdata;
    end

    assign req = |(flags & enables);

endmodule

// File: rtl/usbirq_cfg_regs.sv
// Control and configuration registers: interrupt gates, priority level,
// double-bank mask and isochronous mask.
// Assumes: write strobes are already decoded per register.
module usbirq_cfg_regs
    import usbirq_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              dbl_wr,
    input  logic              iso_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic [NUM_EP-1:0] mask_wdata,
    output logic [CTL_W-1:0]  ctl,
    output logic [NUM_EP-1:0] dbl_mask,
    output logic [NUM_EP-1:0] iso_mask
);

    // Purpose: hold gates and priority bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= '0;
        else if (ctl_wr) ctl <= ctl_wdata;
    end

    // Purpose: hold the per-endpoint double-bank configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)      dbl_mask <= '0;
        else if (dbl_wr) dbl_mask <= mask_wdata;
    end

    // Purpose: hold the per-endpoint isochronous configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)      iso_mask <= '0;
        else if (iso_wr) iso_mask <= mask_wdata;
    end

endmodule

// File: rtl/usbirq_req_merge.sv
// Combines the per-source requests with the USB and global gates into one
// registered interrupt level.
// Assumes: source requests are already masked by their enables.
module usbirq_req_merge #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               glob_en,
    input  logic               usb_en,
    output logic               irq
);

    // Purpose: register the gated OR of all sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= glob_en & usb_en & (|src_req);
    end

endmodule

// File: rtl/usb_irq_aggregator.sv
// Top of the USB device interrupt aggregator: decodes the register port,
// instantiates one flag block per endpoint, the device flag block, the
// configuration registers and the request merge, and drives read data.
// Assumes: NUM_EP between 1 and 8; strobes are one cycle wide.
module usb_irq_aggregator
    import usbirq_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int DATA_W = (NUM_EP > EP_FLAG_W) ? NUM_EP : EP_FLAG_W,
    parameter int ADDR_W = $clog2(ADR_EP_BASE + 2 * NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] ep_tx_ack,
    input  logic [NUM_EP-1:0] ep_out_b0,
    input  logic [NUM_EP-1:0] ep_out_b1,
    input  logic [NUM_EP-1:0] ep_setup,
    input  logic [NUM_EP-1:0] ep_stall,
    input  logic              bus_sof,
    input  logic              bus_suspend,
    input  logic              bus_resume,
    input  logic              bus_reset,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic [1:0]        irq_level
);

    localparam int NUM_SRC = NUM_EP + 1;

    logic [EP_FLAG_W-1:0]        ep_flags [NUM_EP];
    logic [EP_FLAG_W-1:0]        ep_en    [NUM_EP];
    logic [NUM_EP-1:0]           ep_clr_wr;
    logic [NUM_EP-1:0]           ep_en_wr;
    logic [NUM_EP*EP_FLAG_W-1:0] ep_flag_all;
    logic [NUM_SRC-1:0]          src_req;
    logic [DEV_FLAG_W-1:0]       dev_flags;
    logic [DEV_FLAG_W-1:0]       dev_en;
    logic                        dev_susp;
    logic [CTL_W-1:0]            ctl;
    logic [NUM_EP-1:0]           dbl_mask;
    logic [NUM_EP-1:0]           iso_mask;
    logic [DATA_W-1:0]           rdata_c;

    // configuration registers
    usbirq_cfg_regs #(.NUM_EP(NUM_EP)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (reg_wr && (reg_waddr == ADDR_W'(ADR_CTRL))),
        .dbl_wr     (reg_wr && (reg_waddr == ADDR_W'(ADR_DBLBANK))),
        .iso_wr     (reg_wr && (reg_waddr == ADDR_W'(ADR_ISO))),
        .ctl_wdata  (reg_wdata[CTL_W-1:0]),
        .mask_wdata (reg_wdata[NUM_EP-1:0]),
        .ctl        (ctl),
        .dbl_mask   (dbl_mask),
        .iso_mask   (iso_mask)
    );

    // device-level flags
    usbirq_dev_flags dev_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sof     (bus_sof),
        .bus_suspend (bus_suspend),
        .bus_resume  (bus_resume),
        .bus_reset   (bus_reset),
        .clr_wr      (reg_wr && (reg_waddr == ADDR_W'(ADR_DEVFLAG))),
        .en_wr       (reg_wr && (reg_waddr == ADDR_W'(ADR_DEVEN))),
        .wdata       (reg_wdata[DEV_FLAG_W-1:0]),
        .flags       (dev_flags),
        .enables     (dev_en),
        .suspended   (dev_susp),
        .req         (src_req[NUM_EP])
    );

    // one flag block per endpoint
    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        assign ep_clr_wr[e] = reg_wr && (reg_waddr == ADDR_W'(ADR_EP_BASE + 2 * e));
        assign ep_en_wr[e]  = reg_wr && (reg_waddr == ADDR_W'(ADR_EP_BASE + 2 * e + 1));

        usbirq_ep_flags ep_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_tx    (ep_tx_ack[e]),
            .evt_out0  (ep_out_b0[e]),
            .evt_out1  (ep_out_b1[e]),
            .evt_setup (ep_setup[e]),
            .evt_stall (ep_stall[e]),
            .dbl_bank  (dbl_mask[e]),
            .iso_ep    (iso_mask[e]),
            .clr_wr    (ep_clr_wr[e]),
            .en_wr     (ep_en_wr[e]),
            .wdata     (reg_wdata[EP_FLAG_W-1:0]),
            .flags     (ep_flags[e]),
            .enables   (ep_en[e]),
            .req       (src_req[e])
        );

        assign ep_flag_all[e*EP_FLAG_W +: EP_FLAG_W] = ep_flags[e];
    end

    // request merge and priority
    usbirq_req_merge #(.NUM_SRC(NUM_SRC)) merge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req (src_req),
        .glob_en (ctl[CTL_GLOBAL]),
        .usb_en  (ctl[CTL_USB]),
        .irq     (irq)
    );

    assign irq_level = {ctl[CTL_PRIO_HI], ctl[CTL_PRIO_LO]};

    // Purpose: select read data by address; unmapped reads return 0.
    always_comb begin
        rdata_c = '0;
        case (reg_raddr)
            ADDR_W'(ADR_CTRL):    rdata_c[CTL_W-1:0]      = ctl;
            ADDR_W'(ADR_DEVFLAG): rdata_c[DEV_FLAG_W-1:0] = dev_flags;
            ADDR_W'(ADR_DEVEN):   rdata_c[DEV_FLAG_W-1:0] = dev_en;
            ADDR_W'(ADR_DBLBANK): rdata_c[NUM_EP-1:0]     = dbl_mask;
            ADDR_W'(ADR_ISO):     rdata_c[NUM_EP-1:0]     = iso_mask;
            default: begin
                for (int e = 0; e < NUM_EP; e++) begin
                    if (reg_raddr == ADDR_W'(ADR_EP_BASE + 2 * e))
                        rdata_c[EP_FLAG_W-1:0] = ep_flags[e];
                    if (reg_raddr == ADDR_W'(ADR_EP_BASE + 2 * e + 1))
                        rdata_c[EP_FLAG_W-1:0] = ep_en[e];
                end
            end
        endcase
    end

    assign reg_rdata = rdata_c;

endmodule

// File: rtl/usbirq_checker.sv
// Property checker for the USB device interrupt aggregator, bound to the
// top module. Observes gates, strobes and flag state.
module usbirq_checker
    import usbirq_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        irq,
    input logic                        glob_en,
    input logic                        usb_en,
    input logic                        bus_suspend,
    input logic [NUM_EP-1:0]           ep_tx_ack,
    input logic [NUM_EP-1:0]           ep_out_b0,
    input logic [NUM_EP-1:0]           ep_setup,
    input logic [NUM_EP-1:0]           ep_stall,
    input logic [NUM_EP-1:0]           dbl_mask,
    input logic [NUM_EP*EP_FLAG_W-1:0] ep_flag_all,
    input logic                        dev_wake,
    input logic                        dev_susp
);

    // R2: a closed global gate keeps the request low next cycle
    a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !irq);

    // R2: a closed USB gate keeps the request low next cycle
    a_r2_usb_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_en |=> !irq);

    // R9: suspend strobe enters the suspended state
    a_r9_suspend_enter: assert property (@(posedge clk) disable iff (!rst_n)
        bus_suspend |=> dev_susp);

    // R9: wake-up flag only rises out of the suspended state
    a_r9_wake_needs_susp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_wake) |-> $past(dev_susp));

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep_chk
        // R5: IN-taken strobe sets its flag
        a_r5_tx_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ep_tx_ack[e] |=> ep_flag_all[e*EP_FLAG_W + EPF_TXDONE]);

        // R5: OUT bank-0 strobe sets its flag
        a_r5_out0_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ep_out_b0[e] |=> ep_flag_all[e*EP_FLAG_W + EPF_OUT0]);

        // R5: SETUP strobe sets its flag
        a_r5_setup_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ep_setup[e] |=> ep_flag_all[e*EP_FLAG_W + EPF_SETUP]);

        // R6: single-bank endpoint never shows a bank-1 flag
        a_r6_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
            !dbl_mask[e] |=> !ep_flag_all[e*EP_FLAG_W + EPF_OUT1]);

        // R7: SETUP without a STALL strobe clears the STALL-sent flag
        a_r7_setup_clears_stall: assert property (@(posedge clk) disable iff (!rst_n)
            (ep_setup[e] && !ep_stall[e]) |=> !ep_flag_all[e*EP_FLAG_W + EPF_STALL]);
    end

endmodule

bind usb_irq_aggregator usbirq_checker #(.NUM_EP(NUM_EP)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq         (irq),
    .glob_en     (ctl[usbirq_pkg::CTL_GLOBAL]),
    .usb_en      (ctl[usbirq_pkg::CTL_USB]),
    .bus_suspend (bus_suspend),
    .ep_tx_ack   (ep_tx_ack),
    .ep_out_b0   (ep_out_b0),
    .ep_setup    (ep_setup),
    .ep_stall    (ep_stall),
    .dbl_mask    (dbl_mask),
    .ep_flag_all (ep_flag_all),
    .dev_wake    (dev_flags[usbirq_pkg::DEVF_WAKE]),
    .dev_susp    (dev_susp)
);

// File: tb/usb_irq_aggregator_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random stimulus,
// all compared against a bench-side model of the requirements.
module usb_irq_aggregator_tb_top;

    localparam int NEP = 4;
    localparam int DW  = 5;
    localparam int AW  = 4;
    localparam int LAST_ADR = 5 + 2 * NEP - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NEP-1:0] tx = '0, o0 = '0, o1 = '0, su = '0, st = '0;
    logic sof = 0, susp = 0, res = 0, brst = 0;
    logic wr = 0;
    logic [AW-1:0] waddr = '0, raddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic irq;
    logic [1:0] lvl;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    logic [3:0] m_ctrl;
    logic [2:0] m_dev, m_deven;
    logic [NEP-1:0] m_dbl, m_iso;
    logic [4:0] m_epf [NEP];
    logic [4:0] m_epen [NEP];
    bit m_susp, m_irq;

    always #2.5 clk = ~clk;

    usb_irq_aggregator #(.NUM_EP(NEP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ep_tx_ack(tx), .ep_out_b0(o0), .ep_out_b1(o1),
        .ep_setup(su), .ep_stall(st),
        .bus_sof(sof), .bus_suspend(susp), .bus_resume(res), .bus_reset(brst),
        .reg_wr(wr), .reg_waddr(waddr), .reg_wdata(wdata),
        .reg_raddr(raddr), .reg_rdata(rdata),
        .irq(irq), .irq_level(lvl)
    );

    function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
        logic [DW-1:0] v = '0;
        int ai = int'(a);
        if (ai == 0) v[3:0] = m_ctrl;
        else if (ai == 1) v[2:0] = m_dev;
        else if (ai == 2) v[2:0] = m_deven;
        else if (ai == 3) v[NEP-1:0] = m_dbl;
        else if (ai == 4) v[NEP-1:0] = m_iso;
        else if (ai <= LAST_ADR) begin
            if ((ai - 5) % 2 == 0) v = m_epf[(ai - 5) / 2];
            else                   v = m_epen[(ai - 5) / 2];
        end
        return v;
    endfunction

    function automatic bit exp_irq_next();
        bit any = |(m_dev & m_deven);
        for (int e = 0; e < NEP; e++) any |= |(m_epf[e] & m_epen[e]);
        return m_ctrl[0] & m_ctrl[1] & any;
    endfunction

    task automatic model_reset();
        m_ctrl = '0; m_dev = '0; m_deven = '0; m_dbl = '0; m_iso = '0;
        m_susp = 0; m_irq = 0;
        for (int e = 0; e < NEP; e++) begin m_epf[e] = '0; m_epen[e] = '0; end
    endtask

    // apply one clock of the current inputs to the model (R4..R9)
    task automatic model_step();
        logic [4:0] setv, clrv;
        logic [2:0] dset, dclr;
        m_irq = exp_irq_next();
        for (int e = 0; e < NEP; e++) begin
            setv = {st[e] & ~m_iso[e], su[e], o1[e] & m_dbl[e], o0[e], tx[e]};
            clrv = (wr && int'(waddr) == 5 + 2 * e) ? wdata : 5'b0;
            clrv[4] = clrv[4] | su[e];
            m_epf[e] = (m_epf[e] & ~clrv) | setv;
            if (!m_dbl[e]) m_epf[e][2] = 1'b0;
        end
        dset = {res & m_susp, susp, sof};
        dclr = (wr && waddr == 4'd1) ? wdata[2:0] : 3'b0;
        m_dev = (m_dev & ~dclr) | dset;
        if (susp) m_susp = 1;
        else if (res || brst) m_susp = 0;
        if (wr) begin
            if (waddr == 4'd0) m_ctrl = wdata[3:0];
            if (waddr == 4'd2) m_deven = wdata[2:0];
            if (waddr == 4'd3) m_dbl = wdata[NEP-1:0];
            if (waddr == 4'd4) m_iso = wdata[NEP-1:0];
            for (int e = 0; e < NEP; e++)
                if (int'(waddr) == 6 + 2 * e) m_epen[e] = wdata;
        end
    endtask

    task automatic clear_inputs();
        tx = '0; o0 = '0; o1 = '0; su = '0; st = '0;
        sof = 0; susp = 0; res = 0; brst = 0; wr = 0;
    endtask

    // one clock: model follows, inputs drop at the next falling edge
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic chk(bit ok, string req, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic check_rd(int a, string req);
        raddr = AW'(a);
        #1;
        chk(rdata === exp_rd(raddr), req, int'(rdata), int'(exp_rd(raddr)));
    endtask

    task automatic check_irq(string req);
        #1;
        chk(irq === m_irq, req, int'(irq), int'(m_irq));
    endtask

    task automatic reg_write(int a, int d);
        wr = 1; waddr = AW'(a); wdata = DW'(d);
        cycle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        clear_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        for (int a = 0; a <= LAST_ADR; a++) check_rd(a, "R1 reset register");
        check_irq("R1 reset irq");
        chk(lvl === 2'b00, "R1 reset level", int'(lvl), 0);

        // R5 R2: flag with enables but gates closed
        reg_write(6, 5'h1F);
        tx[0] = 1; cycle();
        check_rd(5, "R5 tx flag set");
        cycle();
        chk(irq === 1'b0, "R2 gates closed", int'(irq), 0);
        reg_write(0, 4'b0001);
        cycle();
        chk(irq === 1'b0, "R2 usb gate closed", int'(irq), 0);
        reg_write(0, 4'b0011);
        check_irq("R2 irq follows write");
        cycle();
        chk(irq === 1'b1, "R2 both gates open", int'(irq), 1);

        // R3: priority level
        reg_write(0, 4'b1011);
        #1 chk(lvl === 2'b10, "R3 level 2", int'(lvl), 2);
        reg_write(0, 4'b0111);
        #1 chk(lvl === 2'b01, "R3 level 1", int'(lvl), 1);
        reg_write(0, 4'b1111);
        #1 chk(lvl === 2'b11, "R3 level 3", int'(lvl), 3);

        // R4: write-one clear, write-zero keeps, event beats clear
        reg_write(5, 5'h00);
        check_rd(5, "R4 write zero keeps");
        reg_write(5, 5'h01);
        check_rd(5, "R4 write one clears");
        cycle();
        chk(irq === 1'b0, "R2 irq drops after clear", int'(irq), 0);
        tx[0] = 1; wr = 1; waddr = 4'd5; wdata = 5'h01; cycle();
        check_rd(5, "R4 event wins over clear");

        // R6: bank-1 only on double-bank endpoints
        o1[1] = 1; cycle();
        check_rd(7, "R6 single bank ignores bank1");
        reg_write(3, 4'b0010);
        o1[1] = 1; o0[1] = 1; cycle();
        check_rd(7, "R6 double bank sets bank1");
        reg_write(3, 4'b0000);
        check_rd(7, "R6 clearing config clears bank1");

        // R7: stall flag, setup clear, iso masking
        st[2] = 1; cycle();
        check_rd(9, "R7 stall set");
        su[2] = 1; cycle();
        check_rd(9, "R7 setup clears stall");
        st[2] = 1; su[2] = 1; cycle();
        check_rd(9, "R7 stall wins over setup");
        reg_write(4, 4'b1000);
        st[3] = 1; cycle();
        check_rd(11, "R7 iso endpoint no stall");

        // R8 R9: device flags and wake arming
        res = 1; cycle();
        check_rd(1, "R9 resume while awake no wake");
        sof = 1; cycle();
        check_rd(1, "R8 sof set");
        susp = 1; cycle();
        check_rd(1, "R8 suspend set");
        res = 1; cycle();
        check_rd(1, "R9 resume while suspended wakes");
        reg_write(1, 3'b111);
        susp = 1; cycle();
        brst = 1; cycle();
        res = 1; cycle();
        check_rd(1, "R9 bus reset leaves suspend");
        reg_write(2, 3'b100);
        susp = 1; cycle();
        res = 1; cycle();
        check_rd(1, "R9 wake after re-suspend");
        cycle();
        check_irq("R2 device wake request");

        // R10 plus all others: seeded random traffic
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            tx = NEP'($urandom) & NEP'($urandom) & NEP'($urandom);
            o0 = NEP'($urandom) & NEP'($urandom) & NEP'($urandom);
            o1 = NEP'($urandom) & NEP'($urandom);
            su = NEP'($urandom) & NEP'($urandom) & NEP'($urandom);
            st = NEP'($urandom) & NEP'($urandom) & NEP'($urandom);
            sof  = ($urandom_range(0, 7) == 0);
            susp = ($urandom_range(0, 15) == 0);
            res  = ($urandom_range(0, 7) == 0);
            brst = ($urandom_range(0, 31) == 0);
            wr   = ($urandom_range(0, 3) == 0);
            waddr = AW'($urandom_range(0, LAST_ADR + 2));
            wdata = DW'($urandom);
            cycle();
            check_rd($urandom_range(0, LAST_ADR + 2), "R10 R4 random readback");
            check_irq("R2 random irq");
            chk(lvl === m_ctrl[3:2], "R3 random level", int'(lvl), int'(m_ctrl[3:2]));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule